// File: doc/BRIEF.md
# Front-end Chip Chain Readout Sequencer

This block runs event readout for a chain of daisy-chained front-end chips, each carrying 128 channels. After a trigger, it issues one readout strobe per clock and takes the 12-bit ADC sample that goes with each strobe. It then writes a framed event into a downstream FIFO for the host link. A header word opens each frame, the data words follow, and a trailer word closes it.

There are two readout modes. In full-scan mode the block reads every channel of every active chip, in a fixed order. In hit-list mode it reads only the channels the chips flag as hit, and each data word is tagged with its chip and channel.

Triggers come either from an external pin or from an internal periodic source, which is used for pedestal runs. The host starts and stops a run. A non-zero event limit ends the run on its own. A synchronous soft reset brings the block back to a clean idle state.

Top module: `rs_readout_seq`

States of the sequencer: `ST_IDLE`, `ST_HEAD`, `ST_READ`, `ST_TAIL`.

Transitions:
- `ST_IDLE` to `ST_HEAD` when a trigger is accepted.
- `ST_HEAD` to `ST_READ` always.
- `ST_READ` to `ST_TAIL` on the last channel, or in hit-list mode on a strobe with no hit.
- `ST_TAIL` to `ST_IDLE` always.
- Any state to `ST_IDLE` on soft reset.

## Requirements
- R1: After reset, `fifo_wr`, `fe_clk`, `running` and `drop_count` are all zero.
- R2: An accepted trigger (sampled high at a clock edge) causes a header word to be written in the next cycle. The header has bits [24:23]=01, bit 16 = the mode (1 = hit-list) and bits [15:0] = the event number. The event number counts completed events since reset or soft reset. The frame closes with a trailer word: bits [24:23]=11 and bits [15:0] = the number of data words.
- R3: In full-scan mode the block issues exactly `chip_count`*128 strobes. Data word n (bits [24:23]=10, sample in [11:0], all other bits zero) carries the sample taken at strobe n. So channel k of chip c appears at strobe c*128+k; for example, chip 1 channel 50 is at strobe 178.
- R4: In hit-list mode the first strobe comes in the cycle right after the header, and it reads the first hit. Each strobe that has `fe_hit_valid` high writes a data word with chip in [22:19], channel in [18:12] and sample in [11:0]. The first strobe with `fe_hit_valid` low writes no data word and ends the list. An event with no hits is a header followed directly by a trailer with count 0.
- R5: When `use_autotrig` is set, a running block triggers itself once every AUTO_PERIOD cycles, and `ext_trig` is ignored.
- R6: While running, a trigger is dropped if a readout is in progress or if `fifo_space` < `chip_count`*128+2. A dropped trigger produces no frame and raises `drop_count` by one.
- R7: With a non-zero `event_limit`, `running` falls after that many events of the run have completed.
- R8: With `event_limit` = 0, the run continues until `run_stop`. An event that is in progress when the stop arrives still completes.
- R9: `soft_reset` forces the sequencer to idle and clears `running`, the event number and `drop_count`. It pulses `fifo_flush` if a frame was partly written.
- R10: While the block is not running, triggers produce no frame and are not counted as drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous reset command from the host |
| run_start | input | 1 | Start pulse for an acquisition run |
| run_stop | input | 1 | Stop pulse for an acquisition run |
| sparse_mode | input | 1 | 1 = hit-list mode, 0 = full-scan mode |
| use_autotrig | input | 1 | Selects the internal periodic trigger |
| chip_count | input | 5 | Number of chips in the chain (1 to 16) |
| event_limit | input | 16 | Events per run; 0 means no limit |
| ext_trig | input | 1 | External trigger, one-cycle pulse |
| fe_hit_valid | input | 1 | Chain reports a hit for the current strobe |
| fe_hit_chip | input | 4 | Chip index of the current hit |
| fe_hit_chan | input | 7 | Channel address of the current hit |
| adc_sample | input | 12 | Converted sample for the current strobe |
| fifo_space | input | 13 | Free words in the downstream FIFO |
| fe_clk | output | 1 | Readout strobe to the chip chain |
| fifo_wr | output | 1 | Write enable to the FIFO |
| fifo_wdata | output | 25 | Frame word |
| fifo_flush | output | 1 | Discard a partly written frame |
| running | output | 1 | Run in progress |
| drop_count | output | 16 | Number of dropped triggers |

## Verification
The assertions take `chip_count` and `sparse_mode` to be constant from the accepted trigger until the trailer, and `chip_count` to be between 1 and 16. They also take a hit list never to run past the chain length. The directed bench only changes these settings while the block is idle. Its hit lists are shorter than the active channel count. Control pulses are applied just after a clock edge, so each one is sampled exactly once.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_READ = 2'd2,
        ST_TAIL = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'b00,
        WK_HEAD = 2'b01,
        WK_DATA = 2'b10,
        WK_TAIL = 2'b11
    } word_kind_t;
endpackage

// File: rtl/rs_trig_sel.sv
module rs_trig_sel #(
    parameter int AUTO_PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enable,
    input  logic use_auto,
    input  logic ext_trig,
    output logic trig
);
    localparam int CNT_W = $clog2(AUTO_PERIOD);

    logic [CNT_W-1:0] tick_cnt;
    logic             auto_hit;

    assign auto_hit = use_auto && enable && (tick_cnt == CNT_W'(AUTO_PERIOD - 1));
    assign trig     = use_auto ? auto_hit : ext_trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (clr || !enable || !use_auto || auto_hit) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // R5: two internal triggers are never back to back
    p_auto_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_auto && trig) |=> !(use_auto && trig));
endmodule

// File: rtl/rs_run_ctl.sv
module rs_run_ctl #(
    parameter int EVT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_reset,
    input  logic             run_start,
    input  logic             run_stop,
    input  logic             event_done,
    input  logic             drop,
    input  logic [EVT_W-1:0] event_limit,
    output logic             running,
    output logic [EVT_W-1:0] evnum,
    output logic [EVT_W-1:0] drop_count
);
    logic [EVT_W-1:0] run_cnt;
    logic             limit_hit;

    assign limit_hit = event_done && (event_limit != '0) && (run_cnt + 1'b1 == event_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running    <= 1'b0;
            run_cnt    <= '0;
            evnum      <= '0;
            drop_count <= '0;
        end else if (soft_reset) begin
            running    <= 1'b0;
            run_cnt    <= '0;
            evnum      <= '0;
            drop_count <= '0;
        end else begin
            if (run_start) begin
                running <= 1'b1;
            end else if (run_stop || limit_hit) begin
                running <= 1'b0;
            end
            if (run_start) begin
                run_cnt <= '0;
            end else if (event_done) begin
                run_cnt <= run_cnt + 1'b1;
            end
            if (event_done) begin
                evnum <= evnum + 1'b1;
            end
            if (drop) begin
                drop_count <= drop_count + 1'b1;
            end
        end
    end

    // R7: the run ends only on stop, soft reset or a non-zero limit
    p_limit_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(run_stop || soft_reset || (event_limit != '0)));

    // R6: the drop counter moves by at most one per cycle
    p_drop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1
                  || drop_count == '0));
endmodule

// File: rtl/rs_word_fmt.sv
module rs_word_fmt
    import rs_pkg::*;
#(
    parameter int CHIP_W   = 4,
    parameter int CHAN_W   = 7,
    parameter int SAMPLE_W = 12,
    parameter int EVT_W    = 16,
    parameter int IDX_W    = 12,
    parameter int WORD_W   = 25
) (
    input  word_kind_t          kind,
    input  logic                sparse,
    input  logic [EVT_W-1:0]    evnum,
    input  logic [IDX_W-1:0]    count,
    input  logic [CHIP_W-1:0]   chip,
    input  logic [CHAN_W-1:0]   chan,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [WORD_W-1:0]   word
);
    localparam int PAY_W = WORD_W - 2;

    logic [PAY_W-1:0] pay;

    always_comb begin
        unique case (kind)
            WK_HEAD: pay = PAY_W'({sparse, evnum});
            WK_DATA: pay = sparse ? PAY_W'({chip, chan, sample}) : PAY_W'(sample);
            WK_TAIL: pay = PAY_W'(count);
            default: pay = '0;
        endcase
        word = {kind, pay};
    end
endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
    import rs_pkg::*;
#(
    parameter int MAX_CHIPS   = 16,
    parameter int CH_PER_CHIP = 128,
    parameter int SAMPLE_W    = 12,
    parameter int EVT_W       = 16,
    parameter int AUTO_PERIOD = 1000,
    localparam int CHIP_W  = $clog2(MAX_CHIPS),
    localparam int CCNT_W  = $clog2(MAX_CHIPS + 1),
    localparam int CHAN_W  = $clog2(CH_PER_CHIP),
    localparam int IDX_W   = $clog2(MAX_CHIPS * CH_PER_CHIP + 1),
    localparam int SPACE_W = IDX_W + 1,
    localparam int WORD_W  = 2 + CHIP_W + CHAN_W + SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_reset,
    input  logic                run_start,
    input  logic                run_stop,
    input  logic                sparse_mode,
    input  logic                use_autotrig,
    input  logic [CCNT_W-1:0]   chip_count,
    input  logic [EVT_W-1:0]    event_limit,
    input  logic                ext_trig,
    input  logic                fe_hit_valid,
    input  logic [CHIP_W-1:0]   fe_hit_chip,
    input  logic [CHAN_W-1:0]   fe_hit_chan,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic [SPACE_W-1:0]  fifo_space,
    output logic                fe_clk,
    output logic                fifo_wr,
    output logic [WORD_W-1:0]   fifo_wdata,
    output logic                fifo_flush,
    output logic                running,
    output logic [EVT_W-1:0]    drop_count
);
    seq_state_t       state, nxt;
    word_kind_t       kind;
    logic [IDX_W-1:0] idx, nwords, total;
    logic             mode_q, trig, space_ok, accept, drop, evt_done;
    logic [EVT_W-1:0] evnum;

    assign total    = IDX_W'(chip_count) * IDX_W'(CH_PER_CHIP);
    assign space_ok = fifo_space >= (SPACE_W'(total) + SPACE_W'(2));
    assign accept   = trig && running && (state == ST_IDLE) && space_ok && !soft_reset;
    assign drop     = trig && running && !accept && !soft_reset;

    rs_trig_sel #(.AUTO_PERIOD(AUTO_PERIOD)) u_trig (
        .clk(clk), .rst_n(rst_n), .clr(soft_reset), .enable(running),
        .use_auto(use_autotrig), .ext_trig(ext_trig), .trig(trig)
    );

    rs_run_ctl #(.EVT_W(EVT_W)) u_run (
        .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .run_start(run_start),
        .run_stop(run_stop), .event_done(evt_done), .drop(drop),
        .event_limit(event_limit), .running(running), .evnum(evnum),
        .drop_count(drop_count)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = ST_HEAD;
            ST_HEAD: nxt = ST_READ;
            ST_READ: if ((mode_q && !fe_hit_valid) || (idx == total - 1'b1)) nxt = ST_TAIL;
            ST_TAIL: nxt = ST_IDLE;
        endcase
        if (soft_reset) nxt = ST_IDLE;
    end

    // event datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            nwords <= '0;
            mode_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) mode_q <= sparse_mode;
                ST_HEAD: begin
                    idx    <= '0;
                    nwords <= '0;
                end
                ST_READ: begin
                    idx <= idx + 1'b1;
                    if (fifo_wr) nwords <= nwords + 1'b1;
                end
                ST_TAIL: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        kind = WK_NONE;
        unique case (state)
            ST_IDLE: kind = WK_NONE;
            ST_HEAD: kind = WK_HEAD;
            ST_READ: kind = (!mode_q || fe_hit_valid) ? WK_DATA : WK_NONE;
            ST_TAIL: kind = WK_TAIL;
        endcase
        fe_clk     = (state == ST_READ);
        fifo_wr    = (kind != WK_NONE) && !soft_reset;
        fifo_flush = soft_reset && (state != ST_IDLE);
        evt_done   = (state == ST_TAIL) && !soft_reset;
    end

    rs_word_fmt #(
        .CHIP_W(CHIP_W), .CHAN_W(CHAN_W), .SAMPLE_W(SAMPLE_W),
        .EVT_W(EVT_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
    ) u_fmt (
        .kind(kind), .sparse(mode_q), .evnum(evnum), .count(nwords),
        .chip(fe_hit_chip), .chan(fe_hit_chan), .sample(adc_sample), .word(fifo_wdata)
    );

    // checker: data words written since the last header
    logic [IDX_W-1:0] chk_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_cnt <= '0;
        else if (fifo_wr && fifo_wdata[WORD_W-1 -: 2] == 2'b01) chk_cnt <= '0;
        else if (fifo_wr && fifo_wdata[WORD_W-1 -: 2] == 2'b10) chk_cnt <= chk_cnt + 1'b1;
    end

    // R2: header in the cycle after an accepted trigger
    p_head_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (soft_reset || (fifo_wr && fifo_wdata[WORD_W-1 -: 2] == 2'b01)));

    // R2: trailer count equals the data words written
    p_tail_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_wdata[WORD_W-1 -: 2] == 2'b11) |-> fifo_wdata[IDX_W-1:0] == chk_cnt);

    // R3: a full scan issues one strobe per channel of the chain
    p_serial_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && !mode_q) |-> idx == total);

    // R10: a stopped idle block writes nothing
    p_quiet_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && state == ST_IDLE) |=> !fifo_wr);
endmodule

// File: tb/rs_readout_seq_tb_top.sv
module rs_readout_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        soft_reset = 0, run_start = 0, run_stop = 0, sparse_mode = 0, use_autotrig = 0;
    logic [4:0]  chip_count = 5'd1;
    logic [15:0] event_limit = '0;
    logic        ext_trig = 0;
    logic        fe_hit_valid;
    logic [3:0]  fe_hit_chip;
    logic [6:0]  fe_hit_chan;
    logic [11:0] adc_sample;
    logic [12:0] fifo_space = 13'd4095;
    logic        fe_clk, fifo_wr, fifo_flush, running;
    logic [24:0] fifo_wdata;
    logic [15:0] drop_count;

    int n_checks = 0, n_fail = 0;
    logic [24:0] words [0:4095];
    int widx = 0;
    logic [11:0] fe_cnt = '0;
    logic [3:0] hc [0:7];
    logic [6:0] hn [0:7];
    int nhits = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_readout_seq #(.AUTO_PERIOD(200)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .run_start(run_start),
        .run_stop(run_stop), .sparse_mode(sparse_mode), .use_autotrig(use_autotrig),
        .chip_count(chip_count), .event_limit(event_limit), .ext_trig(ext_trig),
        .fe_hit_valid(fe_hit_valid), .fe_hit_chip(fe_hit_chip), .fe_hit_chan(fe_hit_chan),
        .adc_sample(adc_sample), .fifo_space(fifo_space), .fe_clk(fe_clk),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_flush(fifo_flush),
        .running(running), .drop_count(drop_count)
    );

    function automatic logic [11:0] pat(int n);
        return 12'((n * 37 + 5) & 32'hFFF);
    endfunction
    function automatic logic [24:0] w_head(logic sp, int ev);
        return {2'b01, 6'b0, sp, 16'(ev)};
    endfunction
    function automatic logic [24:0] w_ser(logic [11:0] s);
        return {2'b10, 11'b0, s};
    endfunction
    function automatic logic [24:0] w_sp(logic [3:0] c, logic [6:0] ch, logic [11:0] s);
        return {2'b10, c, ch, s};
    endfunction
    function automatic logic [24:0] w_tail(int c);
        return {2'b11, 7'b0, 16'(c)};
    endfunction

    // chip-chain model: strobe counter restarts at each header
    assign fe_hit_valid = (int'(fe_cnt) < nhits);
    assign fe_hit_chip  = hc[fe_cnt[2:0]];
    assign fe_hit_chan  = hn[fe_cnt[2:0]];
    assign adc_sample   = pat(int'(fe_cnt));
    always @(posedge clk) begin
        if (fifo_wr && fifo_wdata[24:23] == 2'b01) fe_cnt <= '0;
        else if (fe_clk) fe_cnt <= fe_cnt + 1'b1;
    end

    always @(negedge clk) begin
        if (fifo_wr && widx < 4096) begin
            words[widx] = fifo_wdata;
            widx++;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic fresh();
        soft_reset = 1; tick(); soft_reset = 0;
        run_start = 1; tick(); run_start = 0;
    endtask

    task automatic fire();
        ext_trig = 1; tick(); ext_trig = 0;
    endtask

    function automatic int count_heads(int from, int upto);
        int h = 0;
        for (int i = from; i < upto; i++) if (words[i][24:23] == 2'b01) h++;
        return h;
    endfunction

    task automatic t_reset();
        chk("R1 fifo_wr", fifo_wr, 0);
        chk("R1 fe_clk", fe_clk, 0);
        chk("R1 running", running, 0);
        chk("R1 drop_count", drop_count, 0);
    endtask

    task automatic t_serial();
        int base, errs;
        sparse_mode = 0; use_autotrig = 0; chip_count = 5'd2; event_limit = 16'd1;
        fresh();
        base = widx;
        fire();
        chk("R2 header next cycle", {fifo_wr, 7'b0, fifo_wdata}, {1'b1, 7'b0, w_head(0, 0)});
        tick(300);
        chk("R3 frame length", widx - base, 258);
        errs = 0;
        for (int n = 0; n < 256; n++) if (words[base + 1 + n] !== w_ser(pat(n))) errs++;
        chk("R3 serial order", errs, 0);
        chk("R3 chip1 chan50 at strobe 178", words[base + 179], w_ser(pat(178)));
        chk("R2 trailer count", words[base + 257], w_tail(256));
        chk("R7 stop after limit", running, 0);
    endtask

    task automatic t_sparse();
        int base;
        sparse_mode = 1; use_autotrig = 0; chip_count = 5'd2; event_limit = 16'd0;
        hc[0] = 4'd0; hn[0] = 7'd5; hc[1] = 4'd1; hn[1] = 7'd50; hc[2] = 4'd1; hn[2] = 7'd127;
        nhits = 3;
        fresh();
        base = widx;
        fire();
        tick();
        chk("R4 first hit on first strobe", {fe_clk, 7'b0, fifo_wdata}, {1'b1, 7'b0, w_sp(0, 5, pat(0))});
        tick(20);
        chk("R4 sparse length", widx - base, 5);
        chk("R4 header mode bit", words[base], w_head(1, 0));
        chk("R4 hit chip1 chan50", words[base + 2], w_sp(1, 50, pat(1)));
        chk("R4 hit chip1 chan127", words[base + 3], w_sp(1, 127, pat(2)));
        chk("R2 sparse trailer", words[base + 4], w_tail(3));
        nhits = 0;
        base = widx;
        fire();
        tick(10);
        chk("R4 empty event length", widx - base, 2);
        chk("R2 event number increments", words[base], w_head(1, 1));
        chk("R4 empty trailer", words[base + 1], w_tail(0));
        chk("R8 still running with limit zero", running, 1);
        run_stop = 1; tick(); run_stop = 0;
        chk("R8 stop command", running, 0);
    endtask

    task automatic t_drop();
        int base;
        sparse_mode = 0; use_autotrig = 0; chip_count = 5'd1; event_limit = 16'd0;
        fresh();
        fire();
        tick(20);
        fire();
        tick(200);
        chk("R6 busy trigger dropped", drop_count, 1);
        base = widx;
        fifo_space = 13'd129;
        fire();
        tick(5);
        chk("R6 no frame when space short", widx - base, 0);
        chk("R6 space drop counted", drop_count, 2);
        fifo_space = 13'd130;
        fire();
        tick(200);
        chk("R6 exact space accepted", widx - base, 130);
        fifo_space = 13'd4095;
        run_stop = 1; tick(); run_stop = 0;
        base = widx;
        fire();
        tick(5);
        chk("R10 no frame when stopped", widx - base, 0);
        chk("R10 no drop when stopped", drop_count, 2);
    endtask

    task automatic t_auto_limit();
        int base;
        sparse_mode = 0; use_autotrig = 1; chip_count = 5'd1; event_limit = 16'd3;
        fresh();
        base = widx;
        tick(1200);
        chk("R7 three events then stop", count_heads(base, widx), 3);
        chk("R5 auto events numbered", words[base + 2 * 130], w_head(0, 2));
        chk("R7 running low", running, 0);
    endtask

    task automatic t_auto_free();
        int base, mid;
        sparse_mode = 0; use_autotrig = 1; chip_count = 5'd1; event_limit = 16'd0;
        fresh();
        base = widx;
        tick(700);
        chk("R8 runs on with limit zero", running, 1);
        run_stop = 1; tick(); run_stop = 0;
        tick(300);
        chk("R5 auto triggers fired", count_heads(base, widx) >= 3, 1);
        chk("R8 last frame completed", words[widx - 1][24:23], 2'b11);
        mid = widx;
        tick(400);
        chk("R8 nothing after stop", widx - mid, 0);
        use_autotrig = 0;
    endtask

    task automatic t_soft_reset();
        int base;
        sparse_mode = 0; use_autotrig = 0; chip_count = 5'd2; event_limit = 16'd0;
        fresh();
        fire();
        tick(300);
        fire();
        tick(50);
        chk("R9 mid-readout strobing", fe_clk, 1);
        soft_reset = 1;
        #1;
        chk("R9 flush pulse", fifo_flush, 1);
        tick();
        soft_reset = 0;
        chk("R9 back to idle", fe_clk, 0);
        chk("R9 run cleared", running, 0);
        run_start = 1; tick(); run_start = 0;
        base = widx;
        fire();
        tick(5);
        chk("R9 event number cleared", words[base], w_head(0, 0));
        tick(300);
    endtask

    task automatic t_full_chain();
        int base;
        sparse_mode = 0; use_autotrig = 0; chip_count = 5'd16; event_limit = 16'd1;
        fresh();
        base = widx;
        fire();
        tick(2100);
        chk("R3 sixteen-chip length", widx - base, 2050);
        chk("R3 last channel", words[base + 2048], w_ser(pat(2047)));
        chk("R2 sixteen-chip trailer", words[base + 2049], w_tail(2048));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_serial();
        t_sparse();
        t_drop();
        t_auto_limit();
        t_auto_free();
        t_soft_reset();
        t_full_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule